// File: doc/BRIEF.md
# Write-only I2C slave byte receiver

This block is the bus front end of a register loader that only ever listens. It watches the two I2C lines, cleans them with a two-flop synchroniser and a stability filter, and finds START and STOP conditions on the filtered lines. It shifts in each byte MSB first and compares the first byte after a START with a fixed 7-bit address and a write bit. A matching address opens the transfer. Every later byte is handed to the loader on a one-cycle strobe with a tag. The tag marks the first byte after the address as the control byte and all others as data bytes.

The block acknowledges through an open-drain enable: when `sda_oe` is high the pad pulls SDA low. The address byte and the control byte are always acknowledged. Data bytes are acknowledged only while the loader holds `sel_i` high, so several loaders can share one address while only the selected one answers data. A STOP that ends an addressed transfer pulses a strobe to the loader. The block never transmits data and never holds SCL low.

Top module: `i2c_wr_slave`

## Requirements
- R1: After reset `sda_oe`, `byte_vld` and `stop_pulse` are all low, and the block waits for a START.
- R2: An address byte equal to the 7-bit parameter `ADDR7` (default binary 0111010) followed by a 0 (write) bit is acknowledged: `sda_oe` is high during the ninth SCL high phase.
- R3: An address byte with another address or with the read bit (1) is not acknowledged. Until the next START the block then gives no acknowledge and no `byte_vld`, and the STOP that ends it gives no `stop_pulse`.
- R4: The first byte after an acknowledged address is delivered with `byte_is_ctrl` = 1 and is acknowledged whatever the level of `sel_i`.
- R5: Every further byte is delivered with `byte_is_ctrl` = 0 and its bits in the order received (first bit = bit 7). It is acknowledged only when `sel_i` is high at the eighth SCL rising edge.
- R6: `byte_vld` is a single-cycle pulse that comes one system clock after the eighth filtered SCL rising edge, while SCL is still high and before the acknowledge slot.
- R7: A pulse on SCL or SDA that lasts fewer than `FILT_N` system clocks changes nothing: it adds no bit and creates no START or STOP.
- R8: A repeated START in the middle of a transfer starts address reception again. The byte after a re-acknowledged address is once more the control byte.
- R9: A STOP after an acknowledged address produces exactly one single-cycle `stop_pulse`.
- R10: `sda_oe` changes only while the filtered SCL is low. It is released within the low phase that follows the ninth clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Raw SCL level from the pad |
| sda_i | input | 1 | Raw SDA level from the pad |
| sel_i | input | 1 | Loader is selected: acknowledge data bytes |
| sda_oe | output | 1 | Open-drain enable; high pulls SDA low |
| byte_vld | output | 1 | One-cycle strobe: a received byte is on `byte_data` |
| byte_data | output | 8 | Last received byte |
| byte_is_ctrl | output | 1 | Tag for the strobed byte: 1 = control byte, 0 = data byte |
| stop_pulse | output | 1 | One-cycle strobe on STOP ending an addressed transfer |

## Verification
The address decoder is swept over all 128 seven-bit addresses with the write bit, and one more pass uses the read bit. This separates the single acknowledged address from every near miss and shows that an ignored transfer stays silent through its following byte and its STOP. Data bytes of all zeros, all ones, single set bits at each end and alternating bits are sent with `sel_i` toggling between bytes. These patterns show bit order, the control/data tag and the gated acknowledge each on its own. Repeated STARTs to a good and then a bad address show that the byte count restarts. A byte sent with short spikes in every SCL low phase and every SDA high phase checks that the filter suppresses false bits and false START/STOP conditions.

// File: rtl/i2c_rx_pkg.sv
package i2c_rx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,   // waiting for START
        ST_BITS,   // shifting bits of a byte
        ST_GAP,    // eighth bit taken, waiting for SCL low
        ST_ACK,    // ninth clock (acknowledge slot)
        ST_SKIP    // not addressed, wait for next START
    } rx_state_t;

    typedef enum logic [1:0] {
        PH_ADDR,
        PH_CTRL,
        PH_DATA
    } rx_phase_t;

    typedef struct packed {
        rx_state_t  st;
        rx_phase_t  ph;
        logic [3:0] bits;
        logic [7:0] shreg;
        logic       ack;
        logic       oe;
        logic       vld;
        logic       ctrl;
        logic       stp;
        logic       scl_p;
        logic       sda_p;
    } rx_regs_t;

    localparam rx_regs_t RX_RST = '{
        st: ST_IDLE, ph: PH_ADDR, bits: 4'd0, shreg: 8'd0,
        ack: 1'b0, oe: 1'b0, vld: 1'b0, ctrl: 1'b0, stp: 1'b0,
        scl_p: 1'b1, sda_p: 1'b1
    };

endpackage

// File: rtl/i2c_line_filter.sv
module i2c_line_filter #(
    parameter int FILT_N = 13
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic line_o
);
    localparam int CW = $clog2(FILT_N + 1);
    localparam logic [CW-1:0] CNT_LAST = CW'(FILT_N - 1);

    logic [1:0]    sync_d, sync_q;
    logic [CW-1:0] cnt_d,  cnt_q;
    logic          out_d,  out_q;

    always_comb begin
        sync_d = {sync_q[0], line_i};
        out_d  = out_q;
        cnt_d  = cnt_q;
        if (sync_q[1] == out_q) begin
            cnt_d = '0;
        end else if (cnt_q == CNT_LAST) begin
            out_d = sync_q[1];
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= 2'b11;
            cnt_q  <= '0;
            out_q  <= 1'b1;
        end else begin
            sync_q <= sync_d;
            cnt_q  <= cnt_d;
            out_q  <= out_d;
        end
    end

    assign line_o = out_q;

    // the filtered level only moves after a full run of differing samples
    AST_FILT_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (out_q != $past(out_q)) |-> ($past(cnt_q) == CNT_LAST)); // R7

endmodule

// File: rtl/i2c_rx_engine.sv
module i2c_rx_engine
    import i2c_rx_pkg::*;
#(
    parameter logic [6:0] ADDR7 = 7'h3A
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_f,
    input  logic       sda_f,
    input  logic       sel_i,
    output logic       sda_oe,
    output logic       byte_vld,
    output logic [7:0] byte_data,
    output logic       byte_is_ctrl,
    output logic       stop_pulse
);
    localparam logic [7:0] ADDR_WR = {ADDR7, 1'b0};

    rx_regs_t q, d;

    logic       scl_rise, scl_fall, bus_start, bus_stop;
    logic [7:0] nxt_byte;

    always_comb begin
        scl_rise  = scl_f & ~q.scl_p;
        scl_fall  = ~scl_f & q.scl_p;
        bus_start = scl_f & q.scl_p & q.sda_p & ~sda_f;
        bus_stop  = scl_f & q.scl_p & ~q.sda_p & sda_f;
        nxt_byte  = {q.shreg[6:0], sda_f};

        d       = q;
        d.vld   = 1'b0;
        d.stp   = 1'b0;
        d.scl_p = scl_f;
        d.sda_p = sda_f;

        if (bus_start) begin
            d.st   = ST_BITS;
            d.ph   = PH_ADDR;
            d.bits = 4'd0;
            d.oe   = 1'b0;
        end else if (bus_stop) begin
            d.stp  = (q.st != ST_IDLE) && (q.st != ST_SKIP) && (q.ph != PH_ADDR);
            d.st   = ST_IDLE;
            d.ph   = PH_ADDR;
            d.oe   = 1'b0;
        end else begin
            unique case (q.st)
                ST_BITS: begin
                    if (scl_rise) begin
                        d.shreg = nxt_byte;
                        d.bits  = 4'(q.bits + 4'd1);
                        if (q.bits == 4'd7) begin
                            d.st = ST_GAP;
                            unique case (q.ph)
                                PH_ADDR: d.ack = (nxt_byte == ADDR_WR);
                                PH_CTRL: begin
                                    d.ack  = 1'b1;
                                    d.vld  = 1'b1;
                                    d.ctrl = 1'b1;
                                end
                                default: begin
                                    d.ack  = sel_i;
                                    d.vld  = 1'b1;
                                    d.ctrl = 1'b0;
                                end
                            endcase
                        end
                    end
                end
                ST_GAP: begin
                    if (scl_fall) begin
                        if ((q.ph == PH_ADDR) && !q.ack) begin
                            d.st = ST_SKIP;
                        end else begin
                            d.st   = ST_ACK;
                            d.oe   = q.ack;
                            d.bits = 4'd0;
                        end
                    end
                end
                ST_ACK: begin
                    if (scl_rise) begin
                        d.bits = 4'd1;
                    end else if (scl_fall && (q.bits != 4'd0)) begin
                        d.oe   = 1'b0;
                        d.st   = ST_BITS;
                        d.bits = 4'd0;
                        d.ph   = (q.ph == PH_ADDR) ? PH_CTRL : PH_DATA;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= RX_RST;
        else        q <= d;
    end

    assign sda_oe       = q.oe;
    assign byte_vld     = q.vld;
    assign byte_data    = q.shreg;
    assign byte_is_ctrl = q.ctrl;
    assign stop_pulse   = q.stp;

    AST_ACK_SCL_LOW:  assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.oe) |-> !scl_f); // R10
    AST_REL_SCL_LOW:  assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.oe) |-> !scl_f); // R10
    AST_STROBE_ONCE:  assert property (@(posedge clk) disable iff (!rst_n)
        q.vld |=> !q.vld); // R6
    AST_STROBE_HIGH:  assert property (@(posedge clk) disable iff (!rst_n)
        q.vld |-> scl_f); // R6
    AST_STOP_ONCE:    assert property (@(posedge clk) disable iff (!rst_n)
        q.stp |=> !q.stp); // R9
    AST_SKIP_QUIET:   assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_SKIP) |-> (!q.oe && !q.vld)); // R3

endmodule

// File: rtl/i2c_wr_slave.sv
module i2c_wr_slave #(
    parameter logic [6:0] ADDR7  = 7'h3A,
    parameter int         FILT_N = 13
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic       sel_i,
    output logic       sda_oe,
    output logic       byte_vld,
    output logic [7:0] byte_data,
    output logic       byte_is_ctrl,
    output logic       stop_pulse
);
    localparam int NLINES = 2;

    logic [NLINES-1:0] raw_lines;
    logic [NLINES-1:0] clean_lines;

    assign raw_lines = {scl_i, sda_i};

    for (genvar g = 0; g < NLINES; g++) begin : g_line
        i2c_line_filter #(.FILT_N(FILT_N)) u_filt (
            .clk    (clk),
            .rst_n  (rst_n),
            .line_i (raw_lines[g]),
            .line_o (clean_lines[g])
        );
    end

    i2c_rx_engine #(.ADDR7(ADDR7)) u_engine (
        .clk          (clk),
        .rst_n        (rst_n),
        .scl_f        (clean_lines[1]),
        .sda_f        (clean_lines[0]),
        .sel_i        (sel_i),
        .sda_oe       (sda_oe),
        .byte_vld     (byte_vld),
        .byte_data    (byte_data),
        .byte_is_ctrl (byte_is_ctrl),
        .stop_pulse   (stop_pulse)
    );

    // reset state of the outputs
    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (!sda_oe && !byte_vld && !stop_pulse)); // R1

endmodule

// File: tb/i2c_wr_slave_test.sv
module i2c_wr_slave_test;
    localparam int FN = 6;
    localparam int H  = 20;
    localparam logic [6:0] MYADDR = 7'h3A;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_drv = 1'b1;
    logic sda_drv = 1'b1;
    logic sel = 1'b0;
    logic sda_oe, byte_vld, byte_is_ctrl, stop_pulse;
    logic [7:0] byte_data;
    logic sda_line;

    assign sda_line = sda_drv & ~sda_oe;

    always #4 clk = ~clk;

    i2c_wr_slave #(.ADDR7(MYADDR), .FILT_N(FN)) uut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_drv), .sda_i(sda_line),
        .sel_i(sel), .sda_oe(sda_oe), .byte_vld(byte_vld),
        .byte_data(byte_data), .byte_is_ctrl(byte_is_ctrl),
        .stop_pulse(stop_pulse)
    );

    int checks = 0;
    int fails  = 0;
    int vld_cnt = 0;
    int stp_cnt = 0;
    logic [7:0] last_data = 8'h00;
    logic last_ctrl = 1'b0;
    logic last_vld_scl = 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (byte_vld) begin
                vld_cnt++;
                last_data    = byte_data;
                last_ctrl    = byte_is_ctrl;
                last_vld_scl = scl_drv;
            end
            if (stop_pulse) stp_cnt++;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic bus_start();
        sda_drv = 1'b1; tick(H);
        scl_drv = 1'b1; tick(H);
        sda_drv = 1'b0; tick(H);
        scl_drv = 1'b0; tick(H);
    endtask

    task automatic bus_stop();
        sda_drv = 1'b0; tick(H);
        scl_drv = 1'b1; tick(H);
        sda_drv = 1'b1; tick(H);
    endtask

    // sends one byte plus the acknowledge clock; glitch adds short spikes
    task automatic send_byte(input logic [7:0] b, input bit glitch,
                             output bit acked, output bit released,
                             output int nv);
        int v0;
        v0 = vld_cnt;
        for (int i = 7; i >= 0; i--) begin
            sda_drv = b[i];
            if (glitch) begin
                tick(6);
                scl_drv = 1'b1; tick(FN - 3);
                scl_drv = 1'b0; tick(H - 6 - (FN - 3));
            end else begin
                tick(H);
            end
            scl_drv = 1'b1;
            if (glitch) begin
                tick(H / 2);
                sda_drv = ~b[i]; tick(FN - 3);
                sda_drv = b[i];  tick(H - H / 2 - (FN - 3));
            end else begin
                tick(H);
            end
            scl_drv = 1'b0;
            tick(4);
        end
        sda_drv = 1'b1;
        tick(H);
        scl_drv = 1'b1;
        tick(H - 2);
        #1 acked = sda_oe;
        tick(2);
        scl_drv = 1'b0;
        tick(H - 2);
        #1 released = !sda_oe;
        tick(4);
        nv = vld_cnt - v0;
    endtask

    bit ack, rel;
    int nv, s0;
    logic [7:0] pats [5] = '{8'h00, 8'hFF, 8'h81, 8'h5A, 8'h01};

    initial begin
        tick(5);
        #1;
        chk(!sda_oe && !byte_vld && !stop_pulse, "R1 reset outputs", {sda_oe, byte_vld, stop_pulse}, 0);
        rst_n = 1'b1;
        tick(5);
        #1 chk(!sda_oe && !byte_vld && !stop_pulse, "R1 idle after reset", {sda_oe, byte_vld, stop_pulse}, 0);

        // address sweep, write bit
        for (int a = 0; a < 128; a++) begin
            bit match;
            match = (a == int'(MYADDR));
            s0 = stp_cnt;
            bus_start();
            send_byte({a[6:0], 1'b0}, 1'b0, ack, rel, nv);
            chk(ack == match, match ? "R2 address ack" : "R3 address nack", ack, match);
            send_byte(8'hA5, 1'b0, ack, rel, nv);
            chk(ack == match && nv == int'(match), "R3/R4 byte after address", nv, int'(match));
            if (match) begin
                chk(last_ctrl == 1'b1 && last_data == 8'hA5, "R4 control tag", last_data, 8'hA5);
            end
            bus_stop();
            chk(stp_cnt - s0 == int'(match), "R9 stop strobe", stp_cnt - s0, int'(match));
        end

        // read bit with matching address
        s0 = stp_cnt;
        bus_start();
        send_byte({MYADDR, 1'b1}, 1'b0, ack, rel, nv);
        chk(!ack, "R3 read bit nack", ack, 0);
        send_byte(8'h12, 1'b0, ack, rel, nv);
        chk(!ack && nv == 0, "R3 ignored after read", nv, 0);
        bus_stop();
        chk(stp_cnt == s0, "R3 no stop strobe", stp_cnt - s0, 0);

        // data patterns with selection toggling
        s0 = stp_cnt;
        bus_start();
        send_byte({MYADDR, 1'b0}, 1'b0, ack, rel, nv);
        chk(ack && rel, "R2 ack and release", {ack, rel}, 3);
        sel = 1'b0;
        send_byte(8'h3C, 1'b0, ack, rel, nv);
        chk(ack && nv == 1 && last_ctrl, "R4 control acked with sel low", {ack, last_ctrl}, 3);
        for (int p = 0; p < 5; p++) begin
            sel = p[0];
            send_byte(pats[p], 1'b0, ack, rel, nv);
            chk(nv == 1 && last_data == pats[p], "R5 data value", last_data, pats[p]);
            chk(!last_ctrl, "R5 data tag", last_ctrl, 0);
            chk(ack == sel, "R5 ack follows sel", ack, sel);
            chk(last_vld_scl == 1'b1, "R6 strobe while SCL high", last_vld_scl, 1);
            chk(rel, "R10 release after ninth clock", rel, 1);
        end
        bus_stop();
        chk(stp_cnt - s0 == 1, "R9 single stop strobe", stp_cnt - s0, 1);

        // repeated start
        sel = 1'b1;
        s0 = stp_cnt;
        bus_start();
        send_byte({MYADDR, 1'b0}, 1'b0, ack, rel, nv);
        send_byte(8'h11, 1'b0, ack, rel, nv);
        send_byte(8'h22, 1'b0, ack, rel, nv);
        chk(!last_ctrl && last_data == 8'h22, "R8 data before restart", last_data, 8'h22);
        bus_start();
        send_byte({MYADDR, 1'b0}, 1'b0, ack, rel, nv);
        chk(ack && nv == 0, "R8 address after restart", ack, 1);
        send_byte(8'h33, 1'b0, ack, rel, nv);
        chk(last_ctrl && last_data == 8'h33, "R8 control after restart", last_ctrl, 1);
        bus_start();
        send_byte(8'h20, 1'b0, ack, rel, nv);
        chk(!ack, "R8 restart to other address", ack, 0);
        send_byte(8'h44, 1'b0, ack, rel, nv);
        chk(nv == 0 && !ack, "R3 silent after restart miss", nv, 0);
        bus_stop();
        chk(stp_cnt == s0, "R9 no strobe after miss", stp_cnt - s0, 0);

        // glitch rejection
        s0 = stp_cnt;
        bus_start();
        send_byte({MYADDR, 1'b0}, 1'b0, ack, rel, nv);
        send_byte(8'h0F, 1'b0, ack, rel, nv);
        send_byte(8'hC6, 1'b1, ack, rel, nv);
        chk(nv == 1 && last_data == 8'hC6 && !last_ctrl, "R7 spikes rejected", last_data, 8'hC6);
        chk(ack, "R7 ack after spiky byte", ack, 1);
        send_byte(8'h6B, 1'b0, ack, rel, nv);
        chk(nv == 1 && last_data == 8'h6B, "R7 framing kept", last_data, 8'h6B);
        bus_stop();
        chk(stp_cnt - s0 == 1, "R7 no false stop", stp_cnt - s0, 1);

        $display("  test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end

    initial begin
        tick(190000);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("  test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end

endmodule